// File: doc/BRIEF.md
# GPIO Port with Set/Clear Registers

This block is a memory-mapped general-purpose I/O port with one bit per pin. It has a simple single-cycle register bus. Software never reads a register back to change a pin. It writes a mask to a dedicated offset instead. One pair of offsets raises or lowers the output level. A second pair turns the output driver on or off. Every pin whose mask bit is 1 is affected, and every pin whose mask bit is 0 keeps its state. Because of this, two agents that own different pins cannot corrupt each other's settings.

The pad side is three plain vectors: output level, output enable, and input. A testbench or pad wrapper can model the bidirectional pad from them. Pad inputs pass through a two-stage synchronizer before software can read them. Read data is registered: it updates at the clock edge that samples a read request and holds until the next read. Registers are 32-bit words in little-endian order, so bit 0 of every mask and of the input word is pin 0.

Top module: `gpio_sc_port`

## Requirements
- R1: While rst_ni is low, and directly after it, pin_out_o, pin_oe_o and bus_rdata_o are all zero; the reset acts asynchronously.
- R2: A write (bus_valid_i=1, bus_write_i=1) to offset 0x00 drives pin_out_o high, from the next clock edge, for every pin whose bus_wdata_i bit is 1.
- R3: A write to offset 0x10 drives pin_out_o low, from the next clock edge, for every pin whose bus_wdata_i bit is 1.
- R4: A write to offset 0x20 sets pin_oe_o to 1 for every pin whose bus_wdata_i bit is 1.
- R5: A write to offset 0x30 sets pin_oe_o to 0 (tri-state) for every pin whose bus_wdata_i bit is 1.
- R6: In any of the four set/clear writes, a pin whose mask bit is 0 keeps both its output level and its enable.
- R7: A read of offset 0x40 returns the synchronized pad levels, with bit n being pin n. Suppose pin_in_i changes before clock edge N. A read sampled at edge N+1 still returns the old level. A read sampled at edge N+2 or later returns the new level.
- R8: bus_rdata_o changes only at an edge that samples a read (bus_valid_i=1, bus_write_i=0). Writes and idle cycles leave it unchanged, and bus_valid_i=0 blocks a write.
- R9: A read of offset 0x00, 0x10, 0x20 or 0x30 returns zero. So does a read of any address that does not exactly equal a mapped offset, such as 0x41 or 0x44.
- R10: A write to offset 0x40 changes neither pin_out_o nor pin_oe_o. A write to any unmapped address changes neither of them either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Transfer request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata_i | input | NUM_PINS (32) | Write mask |
| bus_rdata_o | output | NUM_PINS (32) | Registered read data |
| pin_out_o | output | NUM_PINS (32) | Output level per pin |
| pin_oe_o | output | NUM_PINS (32) | Output driver enable per pin |
| pin_in_i | input | NUM_PINS (32) | Asynchronous pad input levels |

## Verification
The hardest case to reach from the ports is the exact latency of the input synchronizer. A pad change must stay hidden from a read sampled one edge after the change and must appear in the read sampled one edge later. The bench therefore changes pin_in_i and starts back-to-back reads of the input offset on the same falling edge. It then checks the returned word on each of the next three edges. Mask isolation at the word's boundaries is exercised by walking a single bit across all pins, for both level and enable. Address aliasing is tested with reads and writes to near-miss addresses next to the mapped offsets.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

  localparam int unsigned OFF_OUT_SET = 'h00;
  localparam int unsigned OFF_OUT_CLR = 'h10;
  localparam int unsigned OFF_OE_SET  = 'h20;
  localparam int unsigned OFF_OE_CLR  = 'h30;
  localparam int unsigned OFF_PIN_IN  = 'h40;

  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_OUT_SET = 3'd1,
    SEL_OUT_CLR = 3'd2,
    SEL_OE_SET  = 3'd3,
    SEL_OE_CLR  = 3'd4,
    SEL_PIN_IN  = 3'd5
  } reg_sel_e;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
  import gpio_sc_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);

  // full-width match: near-miss addresses decode to nothing
  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i == ADDR_W'(OFF_OUT_SET)) sel_o = SEL_OUT_SET;
    if (addr_i == ADDR_W'(OFF_OUT_CLR)) sel_o = SEL_OUT_CLR;
    if (addr_i == ADDR_W'(OFF_OE_SET))  sel_o = SEL_OE_SET;
    if (addr_i == ADDR_W'(OFF_OE_CLR))  sel_o = SEL_OE_CLR;
    if (addr_i == ADDR_W'(OFF_PIN_IN))  sel_o = SEL_PIN_IN;
  end

endmodule

// File: rtl/gpio_sc_setclr.sv
module gpio_sc_setclr #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[b] <= 1'b0;
      else if (clr_i[b]) q_o[b] <= 1'b0;
      else if (set_i[b]) q_o[b] <= 1'b1;
    end
  end

endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_sc_port.sv
module gpio_sc_port
  import gpio_sc_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  output logic [NUM_PINS-1:0] pin_out_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  input  logic [NUM_PINS-1:0] pin_in_i
);

  localparam logic [NUM_PINS-1:0] ZERO_W = '0;

  reg_sel_e            sel;
  logic                wr_go, rd_go;
  logic [NUM_PINS-1:0] out_set, out_clr, oe_set, oe_clr;
  logic [NUM_PINS-1:0] in_sync;

  gpio_sc_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign wr_go = bus_valid_i &  bus_write_i;
  assign rd_go = bus_valid_i & ~bus_write_i;

  assign out_set = (wr_go && sel == SEL_OUT_SET) ? bus_wdata_i : ZERO_W;
  assign out_clr = (wr_go && sel == SEL_OUT_CLR) ? bus_wdata_i : ZERO_W;
  assign oe_set  = (wr_go && sel == SEL_OE_SET)  ? bus_wdata_i : ZERO_W;
  assign oe_clr  = (wr_go && sel == SEL_OE_CLR)  ? bus_wdata_i : ZERO_W;

  gpio_sc_setclr #(.WIDTH(NUM_PINS)) u_level (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (out_set),
    .clr_i  (out_clr),
    .q_o    (pin_out_o)
  );

  gpio_sc_setclr #(.WIDTH(NUM_PINS)) u_drive (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (oe_set),
    .clr_i  (oe_clr),
    .q_o    (pin_oe_o)
  );

  gpio_sc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (in_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    bus_rdata_o <= '0;
    else if (rd_go) bus_rdata_o <= (sel == SEL_PIN_IN) ? in_sync : ZERO_W;
  end

  // R2
  p_out_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && bus_addr_i == ADDR_W'(OFF_OUT_SET))
      |=> ((pin_out_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  // R3
  p_out_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && bus_addr_i == ADDR_W'(OFF_OUT_CLR))
      |=> ((pin_out_o & $past(bus_wdata_i)) == ZERO_W));
  // R4
  p_oe_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && bus_addr_i == ADDR_W'(OFF_OE_SET))
      |=> ((pin_oe_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  // R5
  p_oe_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_go && bus_addr_i == ADDR_W'(OFF_OE_CLR))
      |=> ((pin_oe_o & $past(bus_wdata_i)) == ZERO_W));
  // R6
  p_mask_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_go |=> ((((pin_out_o ^ $past(pin_out_o)) | (pin_oe_o ^ $past(pin_oe_o)))
                & ~$past(bus_wdata_i)) == ZERO_W));
  // R7
  p_in_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && bus_addr_i == ADDR_W'(OFF_PIN_IN)) |=> (bus_rdata_o == $past(in_sync)));
  // R8
  p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(bus_rdata_o));
  // R9
  p_rd_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && bus_addr_i != ADDR_W'(OFF_PIN_IN)) |=> (bus_rdata_o == ZERO_W));
  // R10
  p_no_touch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_go && (bus_addr_i == ADDR_W'(OFF_OUT_SET) || bus_addr_i == ADDR_W'(OFF_OUT_CLR) ||
                bus_addr_i == ADDR_W'(OFF_OE_SET)  || bus_addr_i == ADDR_W'(OFF_OE_CLR)))
      |=> ($stable(pin_out_o) && $stable(pin_oe_o)));

endmodule

// File: tb/gpio_sc_port_tb.sv
module gpio_sc_port_tb_top;

  localparam int unsigned NP = 32;
  localparam int unsigned AW = 8;
  localparam logic [31:0] IN_PAT = 32'hC3A5_1E69;
  localparam logic [31:0] IN_NEW = 32'h5A5A_A5A5;
  localparam logic [1:0]  OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] e_out;
    logic [31:0] e_oe;
    logic [31:0] e_rd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   8'h00, 32'hF0F0_00FF, 32'hF0F0_00FF, 32'h0000_0000, 32'h0, 8'd2},  // R2
    '{OP_WR,   8'h00, 32'h0000_0F00, 32'hF0F0_0FFF, 32'h0000_0000, 32'h0, 8'd6},  // R6
    '{OP_WR,   8'h10, 32'h00F0_000F, 32'hF000_0FF0, 32'h0000_0000, 32'h0, 8'd3},  // R3
    '{OP_WR,   8'h20, 32'h0000_FFFF, 32'hF000_0FF0, 32'h0000_FFFF, 32'h0, 8'd4},  // R4
    '{OP_WR,   8'h20, 32'h8000_0000, 32'hF000_0FF0, 32'h8000_FFFF, 32'h0, 8'd6},  // R6
    '{OP_WR,   8'h30, 32'h0000_00F0, 32'hF000_0FF0, 32'h8000_FF0F, 32'h0, 8'd5},  // R5
    '{OP_RD,   8'h40, 32'h0,         32'hF000_0FF0, 32'h8000_FF0F, IN_PAT, 8'd7}, // R7
    '{OP_RD,   8'h10, 32'h0,         32'hF000_0FF0, 32'h8000_FF0F, 32'h0, 8'd9},  // R9
    '{OP_RD,   8'h40, 32'h0,         32'hF000_0FF0, 32'h8000_FF0F, IN_PAT, 8'd7}, // R7
    '{OP_WR,   8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd8}, // R8
    '{OP_WR,   8'h40, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd10},// R10
    '{OP_WR,   8'h44, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd10},// R10
    '{OP_WR,   8'h14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd10},// R10
    '{OP_RD,   8'h40, 32'h0,         32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd7}, // R7
    '{OP_RD,   8'h44, 32'h0,         32'hFFFF_FFFF, 32'h8000_FF0F, 32'h0, 8'd9},  // R9
    '{OP_RD,   8'h40, 32'h0,         32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd7}, // R7
    '{OP_IDLE, 8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8000_FF0F, IN_PAT, 8'd8}, // R8
    '{OP_RD,   8'h30, 32'h0,         32'hFFFF_FFFF, 32'h8000_FF0F, 32'h0, 8'd9},  // R9
    '{OP_WR,   8'h10, 32'h0000_FFFF, 32'hFFFF_0000, 32'h8000_FF0F, 32'h0, 8'd3},  // R3
    '{OP_WR,   8'h30, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'h0000_0000, 32'h0, 8'd5},  // R5
    '{OP_RD,   8'h40, 32'h0,         32'hFFFF_0000, 32'h0000_0000, IN_PAT, 8'd7}, // R7
    '{OP_RD,   8'h41, 32'h0,         32'hFFFF_0000, 32'h0000_0000, 32'h0, 8'd9}   // R9
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_valid_i = 1'b0;
  logic          bus_write_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [NP-1:0] bus_wdata_i = '0;
  logic [NP-1:0] bus_rdata_o, pin_out_o, pin_oe_o;
  logic [NP-1:0] pin_in_i = IN_PAT;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  gpio_sc_port #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pin_out_o   (pin_out_o),
    .pin_oe_o    (pin_oe_o),
    .pin_in_i    (pin_in_i)
  );

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %08h expected %08h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic do_op(input logic [1:0] op, input logic [7:0] addr, input logic [31:0] data);
    bus_valid_i = (op != OP_IDLE);
    bus_write_i = (op != OP_RD);
    bus_addr_i  = addr;
    bus_wdata_i = data;
    @(negedge clk_i);
    bus_valid_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    #5;
    check(1, "out in reset", pin_out_o, 32'h0);
    check(1, "oe in reset", pin_oe_o, 32'h0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, "out after reset", pin_out_o, 32'h0);
    check(1, "oe after reset", pin_oe_o, 32'h0);
    check(1, "rdata after reset", bus_rdata_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op, VECS[i].addr, VECS[i].data);
      check(int'(VECS[i].req), $sformatf("vec %0d out", i), pin_out_o, VECS[i].e_out);
      check(int'(VECS[i].req), $sformatf("vec %0d oe", i), pin_oe_o, VECS[i].e_oe);
      check(int'(VECS[i].req), $sformatf("vec %0d rdata", i), bus_rdata_o, VECS[i].e_rd);
    end

    // R6: single-bit masks walked across every pin, level and enable
    do_op(OP_WR, 8'h10, 32'hFFFF_FFFF);
    for (int p = 0; p < NP; p++) begin
      do_op(OP_WR, 8'h00, 32'h1 << p);
      check(6, $sformatf("walk out set pin %0d", p), pin_out_o, 32'h1 << p);
      do_op(OP_WR, 8'h20, 32'h1 << p);
      check(6, $sformatf("walk oe set pin %0d", p), pin_oe_o, 32'h1 << p);
      do_op(OP_WR, 8'h10, 32'h1 << p);
      check(6, $sformatf("walk out clr pin %0d", p), pin_out_o, 32'h0);
      do_op(OP_WR, 8'h30, 32'h1 << p);
      check(6, $sformatf("walk oe clr pin %0d", p), pin_oe_o, 32'h0);
    end

    // R7: synchronizer latency, pad change and reads start on one falling edge
    pin_in_i    = IN_NEW;
    bus_valid_i = 1'b1;
    bus_write_i = 1'b0;
    bus_addr_i  = 8'h40;
    @(negedge clk_i);
    check(7, "read at edge N", bus_rdata_o, IN_PAT);
    @(negedge clk_i);
    check(7, "read at edge N+1", bus_rdata_o, IN_PAT);
    @(negedge clk_i);
    check(7, "read at edge N+2", bus_rdata_o, IN_NEW);
    bus_valid_i = 1'b0;

    // R1: asynchronous reset in mid-run
    do_op(OP_WR, 8'h00, 32'hA5A5_5A5A);
    do_op(OP_WR, 8'h20, 32'h0F0F_F0F0);
    check(2, "out before reset", pin_out_o, 32'hA5A5_5A5A);
    check(4, "oe before reset", pin_oe_o, 32'h0F0F_F0F0);
    #3 rst_ni = 1'b0;
    #1;
    check(1, "out async reset", pin_out_o, 32'h0);
    check(1, "oe async reset", pin_oe_o, 32'h0);
    check(1, "rdata async reset", bus_rdata_o, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1'b1;
    finish_run();
  end

endmodule